// File: doc/BRIEF.md
# Dual-Mode I/O Address Remapper

This block sits on the processor bus in front of a PCI I/O space. It registers each processor request, classifies its address into one of three processor windows, and for requests that land in the I/O window it issues one downstream I/O cycle. The address of that cycle is the remapped I/O offset with the I/O window base added back. An 8 MiB window at the start of the I/O region is remapped, and it has two address layouts. In the flat layout the offset is cut to 16 bits. In the sparse layout the low five offset bits are kept and offset bits 12 to 26 are moved down by seven places. A level input picks the layout and is captured with every request, so software may switch layouts between any two accesses. The rest of the I/O region passes its offset through unchanged.

Requests carry a byte count of 1, 2 or 4. Data is little-endian and sits on the low byte lanes. Unaligned addresses are accepted as given. Read data coming back from the I/O side is zero-extended to the access size in the same cycle. Requests that hit the PCI memory window or the boot ROM window are only flagged here. A request that hits no window returns all-ones.

Top module: `io_window_remap`

## Requirements
- R1: After reset, io_valid, rsp_valid, hit_io, hit_mem, hit_rom and size_err are all 0, and rsp_rdata is 0.
- R2: With sparse_mode low, a request at CPU address A with 0x8000_0000 <= A < 0x8080_0000 produces io_addr = 0x8000_0000 + ((A - 0x8000_0000) & 0xFFFF).
- R3: With sparse_mode high, a request in the same 8 MiB window produces io_addr = 0x8000_0000 + ((off & 0x1F) | ((off & 0x07FF_F000) >> 7)), where off = A - 0x8000_0000.
- R4: sparse_mode is sampled together with each request. The same address issued twice with different mode levels yields the flat result and then the sparse result.
- R5: A request with 0x8080_0000 <= A < 0xBF80_0000 produces io_addr = A unchanged, whatever the mode.
- R6: hit_io is set for 0x8000_0000 <= A < 0xBF80_0000, hit_mem for 0xC000_0000 <= A < 0xFF00_0000, and hit_rom for A >= 0xFFF0_0000. At most one hit flag is set for any request.
- R7: req_size is a byte count. Any value other than 1, 2 or 4 sets size_err, produces no downstream cycle and returns all-ones read data.
- R8: For a valid I/O hit, rsp_rdata is io_rdata zero-extended from the low req_size bytes (1: bits 7:0, 2: bits 15:0, 4: all 32 bits).
- R9: A request that hits no window returns rsp_rdata = 0xFFFF_FFFF. A memory or ROM hit returns 0.
- R10: On an I/O cycle, io_write equals req_write, io_size equals req_size, and io_wdata is req_wdata with the bytes above req_size cleared.
- R11: io_valid is raised only for requests that hit the I/O window with a legal size.
- R12: Outputs appear exactly one cycle after req_valid is sampled high and last one cycle. rsp_valid follows every request, and without a request io_valid and rsp_valid are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sparse_mode | input | 1 | Layout select: 0 flat 64 KiB, 1 sparse 8 MiB |
| req_valid | input | 1 | Processor request strobe |
| req_addr | input | 32 | Processor byte address |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, low lanes |
| io_valid | output | 1 | Downstream I/O cycle strobe |
| io_addr | output | 32 | Remapped I/O address including base |
| io_write | output | 1 | Downstream direction |
| io_size | output | 3 | Downstream byte count |
| io_wdata | output | 32 | Size-masked write data |
| io_rdata | input | 32 | Read data from the I/O side, same cycle as io_valid |
| rsp_valid | output | 1 | Response strobe to the processor |
| rsp_rdata | output | 32 | Packed read data to the processor |
| hit_io | output | 1 | Request hit the I/O window |
| hit_mem | output | 1 | Request hit the PCI memory window |
| hit_rom | output | 1 | Request hit the boot ROM window |
| size_err | output | 1 | Illegal access size |

## Verification
The bench goes after the sparse bit packing with several hundred scattered window offsets, and it also walks each moved bit on its own. A wrong shift or mask would send a moved bit onto the wrong I/O address bit, or would let bits 5 to 11 leak into the result. It toggles the mode between back-to-back accesses to the same address, so a design that latched the mode late or ignored it would return the wrong layout. It probes the addresses on both sides of every window edge (the end of the 8 MiB window, the end of the I/O region, the gaps, and the ROM base), where an off-by-one compare would flag the wrong window or issue a stray cycle. Every illegal size and all three legal sizes are swept to catch lane masks that keep too many bytes and errors that still start a cycle.

// File: rtl/io_remap_pkg.sv
package io_remap_pkg;

   typedef enum logic [1:0] {
      REGION_NONE = 2'd0,
      REGION_IO   = 2'd1,
      REGION_MEM  = 2'd2,
      REGION_ROM  = 2'd3
   } region_e;

   function automatic logic size_legal(input logic [2:0] nbytes);
      return (nbytes == 3'd1) || (nbytes == 3'd2) || (nbytes == 3'd4);
   endfunction

endpackage

// File: rtl/io_region_decode.sv
module io_region_decode
   import io_remap_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] IO_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] IO_SPAN  = 32'h3F80_0000,
   parameter logic [ADDR_W-1:0] MEM_BASE = 32'hC000_0000,
   parameter logic [ADDR_W-1:0] MEM_SPAN = 32'h3F00_0000,
   parameter logic [ADDR_W-1:0] ROM_SIZE = 32'h0010_0000
) (
   input  logic [ADDR_W-1:0] addr,
   output region_e           region
);
   localparam logic [ADDR_W-1:0] ROM_BASE = ~(ROM_SIZE - 1'b1);

   logic [ADDR_W-1:0] io_off, mem_off;
   logic              in_io, in_mem, in_rom;

   assign io_off  = addr - IO_BASE;
   assign mem_off = addr - MEM_BASE;
   assign in_io   = (addr >= IO_BASE)  && (io_off  < IO_SPAN);
   assign in_mem  = (addr >= MEM_BASE) && (mem_off < MEM_SPAN);
   assign in_rom  = (addr >= ROM_BASE);

   always_comb begin
      if (in_io)       region = REGION_IO;
      else if (in_mem) region = REGION_MEM;
      else if (in_rom) region = REGION_ROM;
      else             region = REGION_NONE;
   end
endmodule

// File: rtl/io_addr_map.sv
module io_addr_map #(
   parameter int                ADDR_W   = 32,
   parameter logic [ADDR_W-1:0] IO_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] WIN_SPAN = 32'h0080_0000,
   parameter int                FLAT_W   = 16,
   parameter int                KEEP_LO  = 5,
   parameter int                HI_LSB   = 12,
   parameter int                HI_MSB   = 26,
   parameter int                SHIFT    = 7
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic              sparse,
   output logic              in_win,
   output logic [ADDR_W-1:0] io_addr
);
   localparam logic [ADDR_W-1:0] FLAT_MASK = ADDR_W'((64'd1 << FLAT_W) - 64'd1);
   localparam logic [ADDR_W-1:0] KEEP_MASK = ADDR_W'((64'd1 << KEEP_LO) - 64'd1);
   localparam logic [ADDR_W-1:0] HI_MASK   = ADDR_W'(((64'd1 << (HI_MSB + 1)) - 64'd1)
                                                     & ~((64'd1 << HI_LSB) - 64'd1));

   if (SHIFT > HI_LSB - KEEP_LO) begin : g_bad_shift
      $error("packed high field would overlap the kept low bits");
   end
   if (FLAT_W > ADDR_W || HI_MSB >= ADDR_W) begin : g_bad_width
      $error("field limits exceed address width");
   end

   logic [ADDR_W-1:0] off, flat_off, sparse_off, map_off;

   assign off        = addr - IO_BASE;
   assign in_win     = off < WIN_SPAN;
   assign flat_off   = off & FLAT_MASK;
   assign sparse_off = (off & KEEP_MASK) | ((off & HI_MASK) >> SHIFT);

   always_comb begin
      if (!in_win)     map_off = off;
      else if (sparse) map_off = sparse_off;
      else             map_off = flat_off;
   end

   assign io_addr = IO_BASE + map_off;
endmodule

// File: rtl/io_lane_pack.sv
module io_lane_pack #(
   parameter int DATA_W = 32
) (
   input  logic [2:0]        nbytes,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   localparam int LANES = DATA_W / 8;

   if (DATA_W % 8 != 0) begin : g_bad_data
      $error("data width must be a whole number of bytes");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign dout[8*i +: 8] = (i < int'(nbytes)) ? din[8*i +: 8] : 8'h00;
   end
endmodule

// File: rtl/io_window_remap.sv
module io_window_remap
   import io_remap_pkg::*;
#(
   parameter int                ADDR_W   = 32,
   parameter int                DATA_W   = 32,
   parameter logic [ADDR_W-1:0] IO_BASE  = 32'h8000_0000,
   parameter logic [ADDR_W-1:0] IO_SPAN  = 32'h3F80_0000,
   parameter logic [ADDR_W-1:0] WIN_SPAN = 32'h0080_0000,
   parameter logic [ADDR_W-1:0] MEM_BASE = 32'hC000_0000,
   parameter logic [ADDR_W-1:0] MEM_SPAN = 32'h3F00_0000,
   parameter logic [ADDR_W-1:0] ROM_SIZE = 32'h0010_0000,
   parameter int                FLAT_W   = 16,
   parameter int                KEEP_LO  = 5,
   parameter int                HI_LSB   = 12,
   parameter int                HI_MSB   = 26,
   parameter int                SHIFT    = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sparse_mode,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic              req_write,
   input  logic [2:0]        req_size,
   input  logic [DATA_W-1:0] req_wdata,
   output logic              io_valid,
   output logic [ADDR_W-1:0] io_addr,
   output logic              io_write,
   output logic [2:0]        io_size,
   output logic [DATA_W-1:0] io_wdata,
   input  logic [DATA_W-1:0] io_rdata,
   output logic              rsp_valid,
   output logic [DATA_W-1:0] rsp_rdata,
   output logic              hit_io,
   output logic              hit_mem,
   output logic              hit_rom,
   output logic              size_err
);
   if (WIN_SPAN > IO_SPAN) begin : g_bad_win
      $error("remapped window must fit inside the I/O region");
   end

   region_e           region;
   logic              win_d;
   logic [ADDR_W-1:0] map_addr;
   logic [DATA_W-1:0] wdata_packed, rdata_packed;

   io_region_decode #(
      .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .IO_SPAN(IO_SPAN),
      .MEM_BASE(MEM_BASE), .MEM_SPAN(MEM_SPAN), .ROM_SIZE(ROM_SIZE)
   ) u_decode (
      .addr(req_addr), .region(region)
   );

   io_addr_map #(
      .ADDR_W(ADDR_W), .IO_BASE(IO_BASE), .WIN_SPAN(WIN_SPAN), .FLAT_W(FLAT_W),
      .KEEP_LO(KEEP_LO), .HI_LSB(HI_LSB), .HI_MSB(HI_MSB), .SHIFT(SHIFT)
   ) u_map (
      .addr(req_addr), .sparse(sparse_mode), .in_win(win_d), .io_addr(map_addr)
   );

   io_lane_pack #(.DATA_W(DATA_W)) u_wpack (
      .nbytes(req_size), .din(req_wdata), .dout(wdata_packed)
   );

   // request stage
   logic              vld_q, err_q, write_q, win_q, mode_q;
   region_e           region_q;
   logic [ADDR_W-1:0] addr_q;
   logic [2:0]        size_q;
   logic [DATA_W-1:0] wdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld_q    <= 1'b0;
         err_q    <= 1'b0;
         write_q  <= 1'b0;
         win_q    <= 1'b0;
         mode_q   <= 1'b0;
         region_q <= REGION_NONE;
         addr_q   <= '0;
         size_q   <= '0;
         wdata_q  <= '0;
      end else begin
         vld_q    <= req_valid;
         err_q    <= req_valid && !size_legal(req_size);
         region_q <= req_valid ? region : REGION_NONE;
         if (req_valid) begin
            write_q <= req_write;
            win_q   <= win_d && (region == REGION_IO);
            mode_q  <= sparse_mode;
            addr_q  <= map_addr;
            size_q  <= req_size;
            wdata_q <= wdata_packed;
         end
      end
   end

   assign hit_io    = (region_q == REGION_IO);
   assign hit_mem   = (region_q == REGION_MEM);
   assign hit_rom   = (region_q == REGION_ROM);
   assign size_err  = err_q;
   assign rsp_valid = vld_q;
   assign io_valid  = vld_q && hit_io && !err_q;
   assign io_addr   = addr_q;
   assign io_write  = write_q;
   assign io_size   = size_q;
   assign io_wdata  = wdata_q;

   io_lane_pack #(.DATA_W(DATA_W)) u_rpack (
      .nbytes(size_q), .din(io_rdata), .dout(rdata_packed)
   );

   always_comb begin
      if (!vld_q)                                   rsp_rdata = '0;
      else if (err_q || region_q == REGION_NONE)    rsp_rdata = '1;
      else if (region_q == REGION_IO)               rsp_rdata = rdata_packed;
      else                                          rsp_rdata = '0;
   end

   // checks beside the logic they guard
   p_flags_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit_io, hit_mem, hit_rom}));
   p_err_no_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
      size_err |-> !io_valid);
   p_cycle_needs_io_r11: assert property (@(posedge clk) disable iff (!rst_n)
      io_valid |-> (hit_io && rsp_valid));
   p_one_cycle_r12: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   p_idle_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> (!rsp_valid && !io_valid));
   p_miss_ones_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !hit_io && !hit_mem && !hit_rom) |-> (rsp_rdata == '1));
   p_sparse_low_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && sparse_mode && win_d && (region == REGION_IO) |=>
         (io_addr[KEEP_LO-1:0] == $past(req_addr[KEEP_LO-1:0])));
   p_flat_bound_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (io_valid && win_q && !mode_q) |-> ((io_addr - IO_BASE) < (ADDR_W'(1) << FLAT_W)));
endmodule

// File: tb/io_window_remap_tb.sv
module io_window_remap_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sparse_mode = 1'b0;
   logic        req_valid = 1'b0;
   logic [31:0] req_addr = '0;
   logic        req_write = 1'b0;
   logic [2:0]  req_size = 3'd4;
   logic [31:0] req_wdata = '0;
   logic [31:0] io_rdata = '0;
   logic        io_valid, io_write, rsp_valid, hit_io, hit_mem, hit_rom, size_err;
   logic [31:0] io_addr, io_wdata, rsp_rdata;
   logic [2:0]  io_size;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   io_window_remap u_dut (
      .clk(clk), .rst_n(rst_n), .sparse_mode(sparse_mode),
      .req_valid(req_valid), .req_addr(req_addr), .req_write(req_write),
      .req_size(req_size), .req_wdata(req_wdata),
      .io_valid(io_valid), .io_addr(io_addr), .io_write(io_write),
      .io_size(io_size), .io_wdata(io_wdata), .io_rdata(io_rdata),
      .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
      .hit_io(hit_io), .hit_mem(hit_mem), .hit_rom(hit_rom), .size_err(size_err)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] exp_addr(input logic [31:0] a, input logic m);
      logic [31:0] off;
      off = a - 32'h8000_0000;
      if (off >= 32'h0080_0000) return a;
      if (m) return 32'h8000_0000 + ((off & 32'h1F) | ((off & 32'h07FF_F000) >> 7));
      return 32'h8000_0000 + (off & 32'hFFFF);
   endfunction

   function automatic logic [1:0] exp_region(input logic [31:0] a);
      if (a >= 32'h8000_0000 && a < 32'hBF80_0000) return 2'd1;
      if (a >= 32'hC000_0000 && a < 32'hFF00_0000) return 2'd2;
      if (a >= 32'hFFF0_0000) return 2'd3;
      return 2'd0;
   endfunction

   function automatic logic [31:0] lane_mask(input logic [2:0] n);
      case (n)
         3'd1: return 32'h0000_00FF;
         3'd2: return 32'h0000_FFFF;
         3'd4: return 32'hFFFF_FFFF;
         default: return 32'h0;
      endcase
   endfunction

   // one request; outputs are registered, so they are sampled at the next falling edge
   task automatic access(input logic [31:0] a, input logic m, input logic wr,
                         input logic [2:0] sz, input logic [31:0] wd, input logic [31:0] rd,
                         input bit full);
      logic [1:0]  reg_e;
      logic        legal;
      logic [31:0] exp_rd;
      @(negedge clk);
      req_valid = 1'b1; req_addr = a; sparse_mode = m;
      req_write = wr; req_size = sz; req_wdata = wd;
      @(negedge clk);
      req_valid = 1'b0; sparse_mode = ~m; req_addr = ~a;
      io_rdata = rd;
      #1;
      reg_e = exp_region(a);
      legal = (sz == 3'd1) || (sz == 3'd2) || (sz == 3'd4);
      if (!legal || reg_e == 2'd0) exp_rd = 32'hFFFF_FFFF;
      else if (reg_e == 2'd1)      exp_rd = rd & lane_mask(sz);
      else                         exp_rd = 32'h0;
      check("R12 rsp_valid", {31'd0, rsp_valid}, 32'd1);
      check("R6 flags", {29'd0, hit_io, hit_mem, hit_rom},
            {29'd0, reg_e == 2'd1, reg_e == 2'd2, reg_e == 2'd3});
      check("R7/R11 io_valid", {31'd0, io_valid}, {31'd0, (reg_e == 2'd1) && legal});
      check("R7 size_err", {31'd0, size_err}, {31'd0, !legal});
      check("R8/R9 rsp_rdata", rsp_rdata, exp_rd);
      if (reg_e == 2'd1 && legal) begin
         if (a - 32'h8000_0000 < 32'h0080_0000)
            check(m ? "R3 io_addr" : "R2 io_addr", io_addr, exp_addr(a, m));
         else
            check("R5 io_addr", io_addr, exp_addr(a, m));
         if (full) begin
            check("R10 io_write", {31'd0, io_write}, {31'd0, wr});
            check("R10 io_size", {29'd0, io_size}, {29'd0, sz});
            check("R10 io_wdata", io_wdata, wd & lane_mask(sz));
         end
      end
      if (full) begin
         @(negedge clk);
         #1;
         check("R12 idle", {30'd0, rsp_valid, io_valid}, 32'd0);
      end
   endtask

   initial begin : watchdog
      #1500000;
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : stim
      repeat (3) @(negedge clk);
      #1;
      // R1 reset state
      check("R1 outputs", {26'd0, io_valid, rsp_valid, hit_io, hit_mem, hit_rom, size_err}, 32'd0);
      check("R1 rdata", rsp_rdata, 32'd0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2 and R3: scattered window offsets in both layouts
      for (int k = 0; k < 600; k++) begin
         logic [31:0] off;
         off = (k * 32'h0001_3579 + k * k * 32'h65) & 32'h007F_FFFF;
         access(32'h8000_0000 + off, k[0], 1'b0, 3'd4, 32'h0, 32'hA5C3_9617 ^ off, 1'b0);
      end
      // R3: walk each single offset bit through the sparse layout
      for (int b = 0; b < 23; b++) begin
         access(32'h8000_0000 | (32'd1 << b), 1'b1, 1'b0, 3'd4, 32'h0, 32'h1, 1'b0);
         access(32'h8000_0000 | (32'd1 << b), 1'b0, 1'b0, 3'd4, 32'h0, 32'h1, 1'b0);
      end
      // R4: mode flips between back-to-back accesses at one address
      for (int k = 0; k < 8; k++) begin
         access(32'h8012_3456 + k * 32'h0004_1111, 1'b0, 1'b0, 3'd2, 32'h0, 32'hBEEF, 1'b1);
         access(32'h8012_3456 + k * 32'h0004_1111, 1'b1, 1'b0, 3'd2, 32'h0, 32'hBEEF, 1'b1);
      end
      // R5 and R6: window edges in both modes
      for (int m = 0; m < 2; m++) begin
         access(32'h807F_FFFF, m[0], 1'b0, 3'd1, 32'h0, 32'h1234_5678, 1'b1);
         access(32'h8080_0000, m[0], 1'b0, 3'd1, 32'h0, 32'h1234_5678, 1'b1);
         access(32'hBF7F_FFFF, m[0], 1'b1, 3'd4, 32'hCAFE_F00D, 32'h0, 1'b1);
         access(32'hBF80_0000, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'h7FFF_FFFF, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'h8000_0000, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hBFFF_FFFF, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hC000_0000, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hFEFF_FFFF, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hFF00_0000, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hFFEF_FFFF, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hFFF0_0000, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
         access(32'hFFFF_FFFF, m[0], 1'b0, 3'd4, 32'h0, 32'h0, 1'b1);
      end
      // R6/R9: coarse sweep of the whole address space
      for (int k = 0; k < 512; k++) begin
         logic [31:0] a;
         a = (32'(k) << 23) | ((32'(k) * 32'h0003_1F7) & 32'h007F_FFFF);
         access(a, k[1], 1'b0, 3'd4, 32'h0, 32'h5A5A_0F0F, 1'b0);
      end
      // R7, R8, R10: every size code, reads and writes, aligned and unaligned
      for (int s = 0; s < 8; s++) begin
         access(32'h8000_0CF9 + 32'(s), 1'b0, 1'b1, 3'(s), 32'h8877_6655, 32'h0, 1'b1);
         access(32'h8000_0CFB, 1'b1, 1'b0, 3'(s), 32'h0, 32'hDEAD_BEEF, 1'b1);
         access(32'h9000_0003, 1'b0, 1'b0, 3'(s), 32'h0, 32'hF1E2_D3C4, 1'b1);
         access(32'hC100_0000, 1'b0, 1'b0, 3'(s), 32'h0, 32'hF1E2_D3C4, 1'b1);
      end

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule